// File: doc/BRIEF.md
# Character Display Message Sequencer

This block is the host side of a four-phase Strobe/Ready command link to a character display controller. Once the go switch is raised, it plays out a short fixed script of display commands: it clears the screen, writes a few characters, backs up one position, writes one more character and finally sends the cursor home. Each step is one complete handshake. The block waits for Ready, raises Strobe, holds it until Ready drops, releases it, and waits for Ready to come back before it starts the next step.

The script is produced by a function in the package. Each entry holds a command, a character and a stop flag. An index register moves to the next entry once per finished handshake. When the stop entry is reached the block halts and raises done. It stays halted until go is released. Raising go again then replays the script from the first entry. The display's own timing is handled by the responder on the far side of the link and is outside this block.

Top module: `lcd_msg_seq`

## Requirements
- R1: While reset is asserted, and right after it, strobe and done are low and cmd and data are zero.
- R2: No transaction starts while go is low in the idle state.
- R3: Strobe rises only at a clock edge where ready is high. While ready stays low, strobe stays low.
- R4: Once strobe is high, it stays high at every edge where ready is high. It falls at the first edge where ready is low.
- R5: Cmd and data hold their values for at least one cycle before strobe rises. They stay unchanged while strobe is high and in the cycle after strobe falls.
- R6: The cmd encoding is 2'b00 write character (character on data), 2'b01 clear, 2'b10 backspace and 2'b11 home. For any command other than write, data is 8'h00.
- R7: One run issues exactly nine transactions in this order: clear, 'H' (8'h48), 'E' (8'h45), 'L' (8'h4C), 'L', 'O' (8'h4F), backspace, '!' (8'h21), home.
- R8: Done goes high only after the last handshake has finished. Strobe is low while done is high.
- R9: If go stays high after a run, no further transaction starts. After go is released, done falls. Raising go again replays the full script from the first entry.
- R10: Toggling go in the middle of a run does not add, drop or restart any transaction.
- R11: Reset in the middle of a run returns the block to idle. The next run starts again from the first entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start switch, level sensitive |
| ready | input | 1 | Responder ready/acknowledge |
| strobe | output | 1 | Request, driven from a flop |
| cmd | output | 2 | Command code |
| data | output | 8 | Character for write commands |
| done | output | 1 | High while halted after a finished run |

## Verification
The bench holds ready low while go is high. A block that ignored Ready would fire strobe into a busy responder. A responder model with a few cycles of latency checks that strobe follows every edge of ready. A block that dropped strobe early or kept it too long would break the four-phase exchange, and one that reloaded cmd during the exchange would show a changing command. The bench toggles go during a run, leaves go high after a run, and applies reset in the middle of a run. A sequencer that restarted, skipped entries, looped forever or resumed at a stale index would show a captured transaction list that differs from the nine expected entries.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUTC  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_BKSP  = 2'b10,
    OP_HOME  = 2'b11
  } op_e;

  typedef struct packed {
    logic       stop;
    op_e        op;
    logic [7:0] ch;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ARM,
    ST_HOLD,
    ST_DRAIN,
    ST_HALT
  } st_e;

  localparam int unsigned SCRIPT_STEPS = 9;

  function automatic step_t mk_step(op_e op, logic [7:0] ch);
    step_t s;
    s.stop = 1'b0;
    s.op   = op;
    s.ch   = (op == OP_PUTC) ? ch : 8'h00;
    return s;
  endfunction

  function automatic step_t script_at(int unsigned i);
    step_t s;
    case (i)
      0:       s = mk_step(OP_CLEAR, 8'h00);
      1:       s = mk_step(OP_PUTC, 8'h48);
      2:       s = mk_step(OP_PUTC, 8'h45);
      3:       s = mk_step(OP_PUTC, 8'h4C);
      4:       s = mk_step(OP_PUTC, 8'h4C);
      5:       s = mk_step(OP_PUTC, 8'h4F);
      6:       s = mk_step(OP_BKSP, 8'h00);
      7:       s = mk_step(OP_PUTC, 8'h21);
      8:       s = mk_step(OP_HOME, 8'h00);
      default: begin
        s      = mk_step(OP_PUTC, 8'h00);
        s.stop = 1'b1;
      end
    endcase
    return s;
  endfunction

  function automatic logic [31:0] idx_next(logic [31:0] i);
    return i + 32'd1;
  endfunction

endpackage

// File: rtl/lcd_seq_script.sv
module lcd_seq_script
  import lcd_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic             stop,
  output op_e              op,
  output logic [7:0]       ch
);
  step_t cur;

  always_comb begin
    cur  = script_at(32'(idx));
    stop = cur.stop;
    op   = cur.op;
    ch   = cur.ch;
  end
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             ready,
  input  logic             stop,
  output logic [IDX_W-1:0] idx,
  output logic             load_en,
  output logic             ev_launch,
  output logic             ev_retire,
  output logic             halted
);
  st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    load_en   = 1'b0;
    ev_launch = 1'b0;
    ev_retire = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d  = ST_FETCH;
          idx_d = '0;
        end
      end
      ST_FETCH: begin
        if (stop) begin
          st_d = ST_HALT;
        end else begin
          load_en = 1'b1;
          st_d    = ST_ARM;
        end
      end
      ST_ARM: begin
        if (ready) begin
          ev_launch = 1'b1;
          st_d      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!ready) begin
          ev_retire = 1'b1;
          idx_d     = IDX_W'(idx_next(32'(idx_q)));
          st_d      = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (ready) st_d = ST_FETCH;
      end
      ST_HALT: begin
        if (!go) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign idx    = idx_q;
  assign halted = (st_q == ST_HALT);
endmodule

// File: rtl/lcd_seq_outreg.sv
module lcd_seq_outreg
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  op_e        op,
  input  logic [7:0] ch,
  input  logic       ev_launch,
  input  logic       ev_retire,
  output logic       strobe,
  output logic [1:0] cmd,
  output logic [7:0] data
);
  logic       strobe_q;
  logic [1:0] cmd_q;
  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cmd_q    <= 2'b00;
      data_q   <= 8'h00;
    end else begin
      if (load_en) begin
        cmd_q  <= op;
        data_q <= ch;
      end
      if (ev_launch)      strobe_q <= 1'b1;
      else if (ev_retire) strobe_q <= 1'b0;
    end
  end

  assign strobe = strobe_q;
  assign cmd    = cmd_q;
  assign data   = data_q;
endmodule

// File: rtl/lcd_msg_seq.sv
module lcd_msg_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       ready,
  output logic       strobe,
  output logic [1:0] cmd,
  output logic [7:0] data,
  output logic       done
);
  localparam int unsigned IDX_CAP = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic             stop_raw, stop;
  op_e              op;
  logic [7:0]       ch;
  logic             load_en;
  logic             ev_launch;
  logic             ev_retire;

  lcd_seq_script #(.IDX_W(IDX_W)) u_script (
    .idx (idx),
    .stop(stop_raw),
    .op  (op),
    .ch  (ch)
  );

  generate
    if (IDX_CAP > SCRIPT_STEPS) begin : g_fit
      assign stop = stop_raw;
    end else begin : g_clip
      assign stop = stop_raw || (32'(idx) >= IDX_CAP - 1);
    end
  endgenerate

  lcd_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .ready    (ready),
    .stop     (stop),
    .idx      (idx),
    .load_en  (load_en),
    .ev_launch(ev_launch),
    .ev_retire(ev_retire),
    .halted   (done)
  );

  lcd_seq_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .op       (op),
    .ch       (ch),
    .ev_launch(ev_launch),
    .ev_retire(ev_retire),
    .strobe   (strobe),
    .cmd      (cmd),
    .data     (data)
  );
endmodule

// File: rtl/lcd_msg_seq_chk.sv
module lcd_msg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       strobe,
  input logic [1:0] cmd,
  input logic [7:0] data,
  input logic       done,
  input logic       ev_launch,
  input logic       ev_retire
);
  p_launch_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(ready));

  p_launch_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> $rose(strobe));

  p_hold_while_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ready) |=> strobe);

  p_drop_on_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ready) |=> !strobe);

  p_retire_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |=> $fell(strobe));

  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($stable(cmd) && $stable(data)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ($stable(cmd) && $stable(data)));

  p_nonwrite_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cmd != 2'b00) |-> (data == 8'h00));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe);
endmodule

bind lcd_msg_seq lcd_msg_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .strobe   (strobe),
  .cmd      (cmd),
  .data     (data),
  .done     (done),
  .ev_launch(ev_launch),
  .ev_retire(ev_retire)
);

// File: tb/lcd_msg_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_msg_seq_tb_top;
  localparam int LAT = 3;
  localparam int RUN_LEN = 9;
  // expected transactions: {cmd[1:0], data[7:0]}
  localparam logic [9:0] EXP_TX [RUN_LEN] = '{
    10'h100, 10'h048, 10'h045, 10'h04C, 10'h04C,
    10'h04F, 10'h200, 10'h021, 10'h300
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic ready_r = 1'b1;
  logic resp_en = 1'b1;
  logic ready;
  logic strobe, done;
  logic [1:0] cmd;
  logic [7:0] data;

  int n_chk = 0;
  int n_bad = 0;
  int n_cap = 0;
  logic [9:0] cap [64];

  always #2 clk = ~clk;
  assign ready = ready_r & resp_en;

  lcd_msg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .ready(ready),
    .strobe(strobe), .cmd(cmd), .data(data), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // responder model: acknowledges each request after LAT cycles
  always begin
    @(posedge clk); #2;
    if (rst_n && strobe && ready) begin
      repeat (LAT) @(posedge clk);
      #2 ready_r = 1'b0;
      while (strobe) begin @(posedge clk); #2; end
      repeat (LAT) @(posedge clk);
      #2 ready_r = 1'b1;
    end
  end

  // protocol monitor, sampled 1 ns after each edge
  logic p_strobe = 1'b0, p_rst = 1'b0;
  logic [1:0] p_cmd = 2'b00;
  logic [7:0] p_data = 8'h00;
  always begin
    @(posedge clk); #1;
    if (rst_n && p_rst) begin
      if (strobe && !p_strobe) begin
        check(ready, "R3 launch without ready", 32'(ready), 32'd1);
        check({cmd, data} == {p_cmd, p_data}, "R5 setup", 32'({cmd, data}), 32'({p_cmd, p_data}));
        if (cmd != 2'b00) check(data == 8'h00, "R6 nonwrite data", 32'(data), 32'h0);
        if (n_cap < 64) cap[n_cap] = {cmd, data};
        n_cap++;
      end
      if (p_strobe) begin
        check(strobe == ready, "R4 strobe follows ready", 32'(strobe), 32'(ready));
        check({cmd, data} == {p_cmd, p_data}, "R5 hold", 32'({cmd, data}), 32'({p_cmd, p_data}));
      end
      if (done) check(!strobe, "R8 quiet when done", 32'(strobe), 32'd0);
    end
    p_strobe = strobe; p_cmd = cmd; p_data = data; p_rst = rst_n;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 2000) begin @(posedge clk); #1; k++; end
    check(done, req, 32'(done), 32'd1);
  endtask

  task automatic cmp_run(input int base, input string req);
    for (int i = 0; i < RUN_LEN; i++) begin
      check(cap[base + i] == EXP_TX[i], req, 32'(cap[base + i]), 32'(EXP_TX[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R1 reset state
    wait_cycles(3);
    check(!strobe && !done, "R1 flags in reset", 32'({strobe, done}), 32'd0);
    check({cmd, data} == 10'h0, "R1 outputs in reset", 32'({cmd, data}), 32'd0);
    rst_n = 1'b1;
    wait_cycles(1);
    check(!strobe && !done && {cmd, data} == 10'h0, "R1 after release", 32'({strobe, done, cmd, data}), 32'd0);

    // R2 no go, no traffic
    wait_cycles(20);
    check(n_cap == 0, "R2 idle without go", 32'(n_cap), 32'd0);

    // R3 ready held low: nothing may launch
    resp_en = 1'b0;
    go = 1'b1;
    wait_cycles(30);
    check(n_cap == 0 && !strobe, "R3 wait for ready", 32'(n_cap), 32'd0);
    check(cmd == 2'b01, "R7 first entry staged", 32'(cmd), 32'd1);
    resp_en = 1'b1;

    // R10 toggle go mid run
    while (n_cap < 3) wait_cycles(1);
    go = 1'b0; wait_cycles(2); go = 1'b1;
    wait_done("R8 done after run");
    check(n_cap == RUN_LEN, "R10 count with go toggled", 32'(n_cap), 32'(RUN_LEN));
    cmp_run(0, "R7 transaction");
    check(!strobe, "R8 strobe low at done", 32'(strobe), 32'd0);

    // R9 go held: no rerun
    wait_cycles(50);
    check(n_cap == RUN_LEN && done, "R9 no rerun with go held", 32'(n_cap), 32'(RUN_LEN));
    go = 1'b0;
    wait_cycles(3);
    check(!done, "R9 done falls on go release", 32'(done), 32'd0);
    go = 1'b1;
    wait_done("R9 second run done");
    check(n_cap == 2 * RUN_LEN, "R9 second run count", 32'(n_cap), 32'(2 * RUN_LEN));
    cmp_run(RUN_LEN, "R9 replay");

    // R11 reset mid run
    go = 1'b0; wait_cycles(3); go = 1'b1;
    while (n_cap < 2 * RUN_LEN + 4) wait_cycles(1);
    wait_cycles(1);
    rst_n = 1'b0;
    wait_cycles(3);
    check(!strobe && !done, "R11 quiet in reset", 32'({strobe, done}), 32'd0);
    rst_n = 1'b1;
    wait_done("R11 run after reset");
    check(n_cap == 3 * RUN_LEN + 4, "R11 count", 32'(n_cap), 32'(3 * RUN_LEN + 4));
    cmp_run(2 * RUN_LEN + 4, "R11 restart from first entry");

    go = 1'b0;
    wait_cycles(5);
    finish_up();
  end
endmodule